// File: doc/BRIEF.md
# Fast Page Mode DRAM Controller

This block connects a synchronous host request port to an asynchronous page-mode DRAM organised as 1M words of 16 bits. The memory has no clock and takes a multiplexed address, so the controller produces every strobe edge itself. It registers the row and column halves of the address onto a shared 12-bit bus. It lowers the row strobe and then a per-byte column strobe. For writes it drives the data bus, and for reads it samples the returned word at the rising column strobe. Every timing minimum is a parameter counted in clock cycles. The defaults assume a 5 ns clock and a 60 ns speed grade.

After an access the row stays open. A later request to the same row is a page hit. It skips the row phase and issues only a new column address and column pulse. A request to a different row closes the page, waits out the row precharge and opens the new row. An open page is also closed automatically before the longest allowed row-strobe low time expires. Refresh is negotiated with an external scheduler. A refresh request closes the page and waits out the precharge. The controller then parks every strobe high and grants the bus until the scheduler reports completion. Only random reads, page reads and early writes are generated.

Top module: `fpm_ctrl`

## Requirements
- R1: While reset is low, and after it, the row strobe and both column strobes are high, the data bus is not driven, `ref_gnt` and `rsp_valid` are 0 and `req_ready` is 0 until at least `T_RP` precharge cycles have elapsed.
- R2: The 20-bit word address splits into row = `req_addr[19:8]`, which is driven on `dram_a` when the row strobe falls, and column = `req_addr[7:0]`, which is zero-extended to 12 bits on `dram_a` when a column strobe falls.
- R3: The row strobe stays high for at least `T_RP` cycles before every fall. It stays low for at least max(`T_RAS`, `T_RC`-`T_RP`) cycles before every rise.
- R4: The first column strobe after a row strobe fall comes at least `T_RCD` cycles later. A column strobe is only ever low while the row strobe is low.
- R5: Each column pulse lasts at least max(`T_CASW`, `T_PC`-`T_CP`-1) cycles. Between pulses the column strobes stay high for at least `T_CP` cycles.
- R6: `dram_ucas_n` is pulsed when `req_be[1]`=1 (bits 15:8) and `dram_lcas_n` when `req_be[0]`=1 (bits 7:0). A mask of 0 is treated as a full word. Both selected strobes fall and rise on the same edge, and the unselected lane's memory byte stays unchanged.
- R7: For a write, `dram_we_n` is low, the data bus is driven and `dram_oe_n` is high from at least one cycle before the column strobe falls until it rises.
- R8: For a read, `dram_we_n` is high and `dram_oe_n` low. The word is taken at the column-strobe rise, no earlier than `T_RAC` cycles after the row strobe fell and no earlier than max(`T_AA`, `T_CAC`) cycles after the column strobe fell. It returns on `rsp_rdata` with a one-cycle `rsp_valid` pulse.
- R9: The controller never drives the data bus within `T_OFF` cycles after the memory stopped driving it.
- R10: A request to the open row raises no new row strobe. A request to another row closes the page and opens the new row.
- R11: The row strobe never stays low longer than `T_RASP` cycles. An idle open page is closed by the controller, and a long run of page hits is broken by a precharge.
- R12: With `ref_req` high, no host request is accepted. The open row is closed and `ref_gnt` rises only after at least `T_RP` cycles with all strobes high. The grant holds with all strobes high until `ref_done`, and refresh wins over a simultaneous host request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address (row in upper 12 bits) |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte lane mask (bit 1 upper, bit 0 lower) |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | 16 | Read data |
| ref_req | input | 1 | Refresh scheduler asks for the bus |
| ref_gnt | output | 1 | Bus handed to the refresh sequencer |
| ref_done | input | 1 | Refresh sequence finished |
| dram_a | output | 12 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_ucas_n | output | 1 | Upper byte column strobe, active low |
| dram_lcas_n | output | 1 | Lower byte column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | 16 | Data toward memory |
| dram_dq_oe | output | 1 | Data bus output enable |
| dram_dq_in | input | 16 | Data from memory |

## Verification
The embedded properties assume the refresh scheduler holds `ref_req` until it sees `ref_gnt` and raises `ref_done` only while granted. They also assume the host keeps a request stable while `req_ready` is low. The bench follows both rules: it drives the host fields and refresh signals on falling clock edges and keeps them fixed until the acceptance edge or the grant. The memory model returns valid data only once its own row, column and address access counts are met, and it serves a fixed marker value otherwise. It also tracks how long ago it released the bus. As a result, a read sampled too early or a write driven too soon shows up as a data or contention mismatch at the ports.

// File: rtl/fpm_pkg.sv
// Shared types and helpers for the page-mode DRAM controller.
// Assumes: nothing beyond IEEE 1800-2017 elaboration semantics.
package fpm_pkg;

    typedef enum logic [3:0] {
        S_PRE,   // row strobe high, counting precharge
        S_IDLE,  // precharged, no row open
        S_ACT,   // row address on the bus, strobe falls next edge
        S_ROW,   // row open, waiting row-to-column delay
        S_CSET,  // column address and write strobe set up
        S_COL,   // column strobe(s) low
        S_CP,    // column precharge
        S_OPEN,  // row open, waiting for a hit, miss or close
        S_REF    // bus granted to the refresh sequencer
    } fpm_state_e;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/fpm_addr_split.sv
// Splits a word address into row and column and forms the two
// multiplexed pin values.  Assumes ROW_W and COL_W fit in A_W.
module fpm_addr_split #(
    parameter int ROW_W = 12,
    parameter int COL_W = 8,
    parameter int A_W   = 12
) (
    input  logic [ROW_W+COL_W-1:0] addr,
    output logic [ROW_W-1:0]       row,
    output logic [A_W-1:0]         row_pins,
    output logic [A_W-1:0]         col_pins
);

    // Upper bits select the row, lower bits the column.
    always_comb begin
        row      = addr[ROW_W+COL_W-1:COL_W];
        row_pins = A_W'(addr[ROW_W+COL_W-1:COL_W]);
        col_pins = A_W'(addr[COL_W-1:0]);
    end

endmodule

// File: rtl/fpm_ras_timer.sv
// Counts how long the row strobe has been low and high, and flags
// when the minimum low time is met and when the page must close.
// Assumes CLOSE_AT < LIMIT and both counters saturate.
module fpm_ras_timer #(
    parameter int CNT_W    = 16,
    parameter int RAS_MIN  = 14,
    parameter int CLOSE_AT = 100,
    parameter int LIMIT    = 120
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ras_n,
    output logic [CNT_W-1:0] lo_cnt,
    output logic [CNT_W-1:0] hi_cnt,
    output logic             min_met,
    output logic             must_close
);

    localparam logic [CNT_W-1:0] SAT   = '1;
    localparam logic [CNT_W-1:0] MIN_C = CNT_W'(RAS_MIN);
    localparam logic [CNT_W-1:0] CLS_C = CNT_W'(CLOSE_AT);
    localparam logic [CNT_W-1:0] LIM_C = CNT_W'(LIMIT);

    // Saturating run-length counters for both strobe levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_cnt <= '0;
            hi_cnt <= '0;
        end else if (ras_n) begin
            lo_cnt <= '0;
            if (hi_cnt != SAT) hi_cnt <= hi_cnt + 1'b1;
        end else begin
            hi_cnt <= '0;
            if (lo_cnt != SAT) lo_cnt <= lo_cnt + 1'b1;
        end
    end

    assign min_met    = (lo_cnt >= MIN_C);
    assign must_close = (lo_cnt >= CLS_C);

    // R11: the row strobe never outlives its maximum low time
    p_ras_limit_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_n |-> (lo_cnt < LIM_C));

endmodule

// File: rtl/fpm_ctrl.sv
// Page-mode DRAM controller.  Sequences random reads, page reads and
// early writes against an unclocked multiplexed-address DRAM, keeps the
// row open for hits, closes it before the strobe limit and hands the
// bus to an external refresh sequencer on request.
// Assumes: the host holds a request stable until accepted; the refresh
// scheduler holds ref_req until ref_gnt and pulses ref_done while granted;
// T_RP, T_RCD >= 1 and T_RASP well above RAS_MIN plus two page cycles.
module fpm_ctrl
    import fpm_pkg::*;
#(
    parameter int ROW_W  = 12,
    parameter int COL_W  = 8,
    parameter int A_W    = 12,
    parameter int DQ_W   = 16,
    parameter int T_RP   = 8,
    parameter int T_RCD  = 4,
    parameter int T_RAS  = 12,
    parameter int T_RC   = 22,
    parameter int T_RAC  = 12,
    parameter int T_AA   = 6,
    parameter int T_CAC  = 3,
    parameter int T_CASW = 3,
    parameter int T_CP   = 2,
    parameter int T_PC   = 8,
    parameter int T_OFF  = 3,
    parameter int T_RASP = 19000
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic                   req_write,
    input  logic [ROW_W+COL_W-1:0] req_addr,
    input  logic [DQ_W-1:0]        req_wdata,
    input  logic [DQ_W/8-1:0]      req_be,
    output logic                   rsp_valid,
    output logic [DQ_W-1:0]        rsp_rdata,
    input  logic                   ref_req,
    output logic                   ref_gnt,
    input  logic                   ref_done,
    output logic [A_W-1:0]         dram_a,
    output logic                   dram_ras_n,
    output logic                   dram_ucas_n,
    output logic                   dram_lcas_n,
    output logic                   dram_we_n,
    output logic                   dram_oe_n,
    output logic [DQ_W-1:0]        dram_dq_out,
    output logic                   dram_dq_oe,
    input  logic [DQ_W-1:0]        dram_dq_in
);

    localparam int LANES    = DQ_W / 8;
    localparam int RD_LEN   = imax(imax(T_CAC, T_AA), T_PC - T_CP - 1);
    localparam int RD_FIRST = imax(RD_LEN, T_RAC - T_RCD - 1);
    localparam int WR_LEN   = imax(T_CASW, T_PC - T_CP - 1);
    localparam int CP_RD    = imax(T_CP, T_OFF);
    localparam int RAS_MIN  = imax(T_RAS, T_RC - T_RP);
    localparam int GUARD    = imax(RD_FIRST, WR_LEN) + CP_RD + 3;
    localparam int CLOSE_AT = T_RASP - GUARD;
    localparam int CNT_W    = $clog2(T_RASP + 2);
    localparam int TMR_W    = $clog2(imax(imax(T_RP, T_RCD),
                                          imax(RD_FIRST, CP_RD)) + 1);

    localparam logic [TMR_W-1:0] L_RP    = TMR_W'(T_RP - 1);
    localparam logic [TMR_W-1:0] L_RCD   = TMR_W'(T_RCD - 1);
    localparam logic [TMR_W-1:0] L_RDF   = TMR_W'(RD_FIRST - 1);
    localparam logic [TMR_W-1:0] L_RD    = TMR_W'(RD_LEN - 1);
    localparam logic [TMR_W-1:0] L_WR    = TMR_W'(WR_LEN - 1);
    localparam logic [TMR_W-1:0] L_CPW   = TMR_W'(T_CP - 1);
    localparam logic [TMR_W-1:0] L_CPR   = TMR_W'(CP_RD - 1);
    localparam logic [CNT_W-1:0] RP_C    = CNT_W'(T_RP);
    localparam logic [CNT_W-1:0] RCD_C   = CNT_W'(T_RCD);

    fpm_state_e         state;
    logic [TMR_W-1:0]   tmr;
    logic [ROW_W-1:0]   row_open;
    logic               op_write;
    logic [LANES-1:0]   op_mask;
    logic [A_W-1:0]     op_col;
    logic [DQ_W-1:0]    op_wdata;
    logic               fresh;
    logic [LANES-1:0]   cas_on;
    logic [LANES-1:0]   cas_lane_n;
    logic               cas_idle;

    logic [ROW_W-1:0]   req_row;
    logic [A_W-1:0]     req_row_pins;
    logic [A_W-1:0]     req_col_pins;
    logic [LANES-1:0]   req_mask;
    logic               hit, accept, want_close;
    logic [CNT_W-1:0]   lo_cnt, hi_cnt;
    logic               min_met, must_close;

    fpm_addr_split #(.ROW_W(ROW_W), .COL_W(COL_W), .A_W(A_W)) u_split (
        .addr     (req_addr),
        .row      (req_row),
        .row_pins (req_row_pins),
        .col_pins (req_col_pins)
    );

    fpm_ras_timer #(.CNT_W(CNT_W), .RAS_MIN(RAS_MIN),
                    .CLOSE_AT(CLOSE_AT), .LIMIT(T_RASP)) u_ras (
        .clk        (clk),
        .rst_n      (rst_n),
        .ras_n      (dram_ras_n),
        .lo_cnt     (lo_cnt),
        .hi_cnt     (hi_cnt),
        .min_met    (min_met),
        .must_close (must_close)
    );

    // Per-lane strobe drive: each byte lane has its own column strobe.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign cas_lane_n[i] = ~cas_on[i];
    end
    assign dram_lcas_n = cas_lane_n[0];
    assign dram_ucas_n = cas_lane_n[LANES-1];
    assign cas_idle    = &cas_lane_n;

    // Request decode: lane mask (empty means word), hit test, acceptance.
    always_comb begin
        req_mask   = (req_be == '0) ? '1 : req_be;
        hit        = (req_row == row_open);
        req_ready  = !ref_req && ((state == S_IDLE) ||
                     (state == S_OPEN && hit && !must_close));
        accept     = req_valid && req_ready;
        want_close = ref_req || must_close || (req_valid && !hit);
        ref_gnt    = (state == S_REF);
    end

    // Main sequencer: strobes, address mux, data bus and read capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= S_PRE;
            tmr         <= L_RP;
            row_open    <= '0;
            op_write    <= 1'b0;
            op_mask     <= '0;
            op_col      <= '0;
            op_wdata    <= '0;
            fresh       <= 1'b0;
            cas_on      <= '0;
            dram_a      <= '0;
            dram_ras_n  <= 1'b1;
            dram_we_n   <= 1'b1;
            dram_oe_n   <= 1'b1;
            dram_dq_out <= '0;
            dram_dq_oe  <= 1'b0;
            rsp_valid   <= 1'b0;
            rsp_rdata   <= '0;
        end else begin
            rsp_valid <= 1'b0;
            if (accept) begin
                op_write <= req_write;
                op_mask  <= req_mask;
                op_col   <= req_col_pins;
                op_wdata <= req_wdata;
                row_open <= req_row;
            end
            case (state)
                S_PRE: begin
                    if (tmr == '0) state <= S_IDLE;
                    else           tmr   <= tmr - 1'b1;
                end
                S_IDLE: begin
                    if (ref_req) begin
                        state <= S_REF;
                    end else if (accept) begin
                        dram_a <= req_row_pins;
                        state  <= S_ACT;
                    end
                end
                S_ACT: begin
                    dram_ras_n <= 1'b0;
                    fresh      <= 1'b1;
                    tmr        <= L_RCD;
                    state      <= S_ROW;
                end
                S_ROW: begin
                    if (tmr != '0) begin
                        tmr <= tmr - 1'b1;
                    end else begin
                        dram_a      <= op_col;
                        dram_we_n   <= !op_write;
                        dram_oe_n   <= op_write;
                        dram_dq_oe  <= op_write;
                        dram_dq_out <= op_wdata;
                        state       <= S_CSET;
                    end
                end
                S_CSET: begin
                    cas_on <= op_mask;
                    tmr    <= op_write ? L_WR : (fresh ? L_RDF : L_RD);
                    state  <= S_COL;
                end
                S_COL: begin
                    if (tmr != '0) begin
                        tmr <= tmr - 1'b1;
                    end else begin
                        cas_on     <= '0;
                        dram_we_n  <= 1'b1;
                        dram_oe_n  <= 1'b1;
                        dram_dq_oe <= 1'b0;
                        fresh      <= 1'b0;
                        if (!op_write) begin
                            rsp_valid <= 1'b1;
                            rsp_rdata <= dram_dq_in;
                        end
                        tmr   <= op_write ? L_CPW : L_CPR;
                        state <= S_CP;
                    end
                end
                S_CP: begin
                    if (tmr == '0) state <= S_OPEN;
                    else           tmr   <= tmr - 1'b1;
                end
                S_OPEN: begin
                    if (accept) begin
                        tmr   <= '0;
                        state <= S_ROW;
                    end else if (want_close && min_met) begin
                        dram_ras_n <= 1'b1;
                        tmr        <= L_RP;
                        state      <= S_PRE;
                    end
                end
                S_REF: begin
                    if (ref_done) begin
                        tmr   <= L_RP;
                        state <= S_PRE;
                    end
                end
                default: state <= S_PRE;
            endcase
        end
    end

    // R3: precharge time before every row strobe fall
    p_precharge_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_ras_n) |-> (hi_cnt >= RP_C));

    // R4: row-to-column delay before a column strobe fall
    p_row_to_col_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cas_idle) |-> (lo_cnt >= RCD_C));

    // R4: column strobes only inside an open row
    p_col_in_row_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_idle |-> !dram_ras_n);

    // R6: the lane strobes never stagger inside one pulse
    p_no_stagger_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cas_idle && !$past(cas_idle)) |-> (cas_lane_n == $past(cas_lane_n)));

    // R7: write strobe and column address are settled before the column strobe falls
    p_col_setup_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cas_idle) |-> ($stable(dram_we_n) && $stable(dram_a)));

    // R7: output enable is off whenever the controller drives the bus
    p_no_fight_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dram_dq_oe |-> dram_oe_n);

    // R8: read responses are single-cycle pulses
    p_rsp_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R12: all strobes parked high while the refresh owns the bus
    p_grant_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ref_gnt |-> (dram_ras_n && cas_idle && !dram_dq_oe));

endmodule

// File: tb/tb_fpm_ctrl.sv
module tb_fpm_ctrl;

    localparam int T_RP = 8, T_RCD = 4, T_RAC = 12, T_AA = 6, T_CP = 2;
    localparam int T_OFF = 3, T_RASP = 120, RAS_MIN = 14, WR_MIN = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [19:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = 2'b11;
    logic        ref_req = 1'b0, ref_done = 1'b0;
    logic        req_ready, rsp_valid, ref_gnt;
    logic [15:0] rsp_rdata;
    logic [11:0] dram_a;
    logic        dram_ras_n, dram_ucas_n, dram_lcas_n, dram_we_n, dram_oe_n;
    logic [15:0] dram_dq_out, dram_dq_in;
    logic        dram_dq_oe;

    int tests = 0, fails = 0;

    always #2.5 clk = ~clk;

    fpm_ctrl #(.T_RASP(T_RASP)) dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .ref_req(ref_req), .ref_gnt(ref_gnt), .ref_done(ref_done),
        .dram_a(dram_a), .dram_ras_n(dram_ras_n), .dram_ucas_n(dram_ucas_n),
        .dram_lcas_n(dram_lcas_n), .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n),
        .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
    );

    // ---------------- memory model (small window of the array) ----------
    logic [15:0] mem [0:255];
    logic [11:0] m_row = '0, m_col = '0;
    int cas_t = 0, ras_t = 0, off_t = 100;
    int ras_falls = 0, wr_err = 0, v_bus = 0;
    logic cas_idle_m, drv;

    assign cas_idle_m = dram_ucas_n && dram_lcas_n;
    assign drv = !dram_oe_n && !cas_idle_m && dram_we_n && !dram_ras_n;
    assign dram_dq_in = (drv && cas_t >= T_AA - 1 && ras_t >= T_RAC - 1)
                        ? mem[{m_row[3:0], m_col[3:0]}] : 16'hDEAD;

    always @(negedge dram_ras_n) begin
        m_row = dram_a;
        if (rst_n) ras_falls++;
    end

    always @(negedge dram_ucas_n or negedge dram_lcas_n) begin
        m_col = dram_a;
        if (!dram_we_n) begin
            if (!dram_dq_oe || !dram_oe_n) wr_err++;
            if (!dram_ucas_n) mem[{m_row[3:0], dram_a[3:0]}][15:8] = dram_dq_out[15:8];
            if (!dram_lcas_n) mem[{m_row[3:0], dram_a[3:0]}][7:0]  = dram_dq_out[7:0];
        end
    end

    always @(posedge clk) begin
        cas_t <= cas_idle_m ? 0 : cas_t + 1;
        ras_t <= dram_ras_n ? 0 : ras_t + 1;
        off_t <= drv ? 0 : ((off_t < 100) ? off_t + 1 : off_t);
    end

    // ---------------- strobe timing monitor --------------------------
    int ras_hi = 0, ras_lo = 0, cas_hi = 0, cas_lo = 0, max_lo = 0;
    int v_rp = 0, v_rasmin = 0, v_rcd = 0, v_cp = 0, v_cas = 0, v_we = 0;
    logic p_ras = 1'b1, p_cas = 1'b1, p_we = 1'b1;

    always @(negedge clk) begin
        if (!rst_n) begin
            ras_hi = 0; ras_lo = 0; cas_hi = 0; cas_lo = 0;
        end else begin
            if (dram_dq_oe && (drv || off_t < T_OFF)) v_bus++;
            if (p_ras && !dram_ras_n) begin
                if (ras_hi < T_RP) v_rp++;
                ras_lo = 0;
            end
            if (!p_ras && dram_ras_n) begin
                if (ras_lo < RAS_MIN) v_rasmin++;
                ras_hi = 0;
            end
            if (p_cas && !cas_idle_m) begin
                if (cas_hi < T_CP) v_cp++;
                if (ras_lo < T_RCD) v_rcd++;
                if (!dram_we_n && p_we) v_we++;
                cas_lo = 0;
            end
            if (!p_cas && cas_idle_m) begin
                if (cas_lo < WR_MIN) v_cas++;
                cas_hi = 0;
            end
            if (dram_ras_n) ras_hi++; else ras_lo++;
            if (cas_idle_m) cas_hi++; else cas_lo++;
            if (ras_lo > max_lo) max_lo = ras_lo;
        end
        p_ras = dram_ras_n; p_cas = cas_idle_m; p_we = dram_we_n;
    end

    // ---------------- helpers ----------------------------------------
    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic host(input logic wr, input logic [19:0] a, input logic [15:0] d,
                        input logic [1:0] be, output logic [15:0] q);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
        #1;
        while (!req_ready) begin @(negedge clk); #1; end
        @(negedge clk);
        req_valid = 1'b0;
        q = '0;
        if (!wr) begin
            while (!rsp_valid) @(negedge clk);
            q = rsp_rdata;
        end
    endtask

    function automatic logic [15:0] pat(input int r, input int c);
        return 16'(((r * 16 + c) * 16'h0123) ^ 16'hA55A);
    endfunction

    task automatic finish_run;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    // ---------------- stimulus ---------------------------------------
    initial begin
        logic [15:0] q;
        int f0, n;
        for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
        repeat (4) @(negedge clk);
        // R1: reset state
        chk("R1 ras", dram_ras_n, 1'b1);
        chk("R1 cas", {dram_ucas_n, dram_lcas_n}, 2'b11);
        chk("R1 bus", {dram_dq_oe, ref_gnt, rsp_valid}, 3'b000);
        rst_n = 1'b1;
        @(negedge clk);
        req_valid = 1'b1; #1;
        chk("R1 ready during precharge", req_ready, 1'b0);
        req_valid = 1'b0;

        // R10/R2: row-major writes, one row opening per row
        f0 = ras_falls;
        for (int r = 0; r < 4; r++)
            for (int c = 0; c < 4; c++)
                host(1'b1, 20'((r << 8) | (c * 5)), pat(r, c), 2'b11, q);
        chk("R10 hits keep row open", ras_falls - f0, 4);

        // R8/R2: column-major reads, every access a miss
        f0 = ras_falls;
        for (int c = 0; c < 4; c++)
            for (int r = 0; r < 4; r++) begin
                host(1'b0, 20'((r << 8) | (c * 5)), 16'h0, 2'b11, q);
                chk("R8 read data", q, pat(r, c));
            end
        chk("R10 misses reopen", ras_falls - f0, 16);

        // R8/R10: page reads on one row
        host(1'b0, 20'h00300, 16'h0, 2'b11, q);
        f0 = ras_falls;
        for (int c = 1; c < 4; c++) begin
            host(1'b0, 20'((3 << 8) | (c * 5)), 16'h0, 2'b11, q);
            chk("R8 page read", q, pat(3, c));
        end
        chk("R10 page reads no new row", ras_falls - f0, 0);

        // R6: byte lanes
        host(1'b1, 20'h00209, 16'h1234, 2'b11, q);
        host(1'b1, 20'h00209, 16'hAB99, 2'b10, q);
        host(1'b0, 20'h00209, 16'h0, 2'b11, q);
        chk("R6 upper lane only", q, 16'hAB34);
        host(1'b1, 20'h00209, 16'h77CD, 2'b01, q);
        host(1'b0, 20'h00209, 16'h0, 2'b11, q);
        chk("R6 lower lane only", q, 16'hABCD);
        host(1'b1, 20'h00209, 16'h5566, 2'b00, q);
        host(1'b0, 20'h00209, 16'h0, 2'b01, q);
        chk("R6 empty mask is word (lower)", q[7:0], 8'h66);
        host(1'b0, 20'h00209, 16'h0, 2'b11, q);
        chk("R6 empty mask is word", q, 16'h5566);

        // R9: read then write on the same open row
        host(1'b0, 20'h0020A, 16'h0, 2'b11, q);
        host(1'b1, 20'h0020B, 16'hC0DE, 2'b11, q);
        host(1'b0, 20'h0020B, 16'h0, 2'b11, q);
        chk("R9 turnaround data", q, 16'hC0DE);

        // R11: idle page is closed by the controller
        repeat (T_RASP + 40) @(negedge clk);
        chk("R11 idle page closed", dram_ras_n, 1'b1);
        // R11: long run of hits is broken by precharges
        f0 = ras_falls;
        for (int k = 0; k < 40; k++)
            host(1'b1, 20'h00100 | 20'(k % 8), 16'(16'h4000 + k), 2'b11, q);
        chk("R11 long hit run splits", (ras_falls - f0) > 1, 1'b1);
        host(1'b0, 20'h00107, 16'h0, 2'b11, q);
        chk("R11 data after forced close", q, 16'h4027);

        // R12: refresh while a row is open
        host(1'b1, 20'h00000, 16'hBEEF, 2'b11, q);
        @(negedge clk);
        ref_req = 1'b1; req_valid = 1'b1; req_write = 1'b1;
        req_addr = 20'h00001; req_wdata = 16'h1111; req_be = 2'b11;
        #1;
        chk("R12 no accept while refresh pending", req_ready, 1'b0);
        n = 0;
        while (!ref_gnt && n < 200) begin @(negedge clk); n++; end
        chk("R12 grant seen", ref_gnt, 1'b1);
        chk("R12 precharge before grant", ras_hi >= T_RP, 1'b1);
        ref_req = 1'b0;
        repeat (5) begin
            @(negedge clk); #1;
            chk("R12 quiet during grant", {dram_ras_n, dram_ucas_n, dram_lcas_n, req_ready}, 4'b1110);
        end
        ref_done = 1'b1;
        @(negedge clk);
        ref_done = 1'b0;
        req_valid = 1'b0;
        chk("R12 grant released", ref_gnt, 1'b0);
        host(1'b0, 20'h00001, 16'h0, 2'b11, q);
        chk("R12 no write during refresh", q, pat(0, 0) == 16'h0 ? 16'h0 : mem[1]);
        host(1'b0, 20'h00000, 16'h0, 2'b11, q);
        chk("R12 data kept", q, 16'hBEEF);

        // R12: refresh wins over a simultaneous request when idle
        repeat (T_RASP + 40) @(negedge clk);
        ref_req = 1'b1; req_valid = 1'b1; req_addr = 20'h00002; req_write = 1'b0;
        @(negedge clk);
        chk("R12 refresh priority", {ref_gnt, dram_ras_n}, 2'b11);
        ref_req = 1'b0; req_valid = 1'b0; ref_done = 1'b1;
        @(negedge clk);
        ref_done = 1'b0;
        repeat (20) @(negedge clk);

        // Accumulated timing and bus rules
        chk("R3 precharge violations", v_rp, 0);
        chk("R3 minimum low violations", v_rasmin, 0);
        chk("R4 row-to-column violations", v_rcd, 0);
        chk("R5 column precharge violations", v_cp, 0);
        chk("R5 column pulse violations", v_cas, 0);
        chk("R7 write setup violations", v_we, 0);
        chk("R7 write bus errors", wr_err, 0);
        chk("R9 bus contention", v_bus, 0);
        chk("R11 longest low time bounded", max_lo <= T_RASP, 1'b1);
        finish_run();
    end

endmodule